// File: doc/BRIEF.md
# Bit-Serial Clock Synthesizer Loader

This block loads a new setting into an external clock synthesizer whose only programming path is two bits of a control register: a data bit and a serial clock bit. Every change of the control value is captured by the synthesizer only when a strobe is pulsed, so the block drives the control value and a separate strobe output and spaces them by a programmable settle wait.

On a start pulse the block captures the current control value, clears the control value and raises a display blank. It then waits a long pre-load settle time and sends two synchronising writes (0, then 1). Next it shifts out a fixed three-bit preamble, the location address and the program word. Each frame bit takes two strobed phases, one with the serial clock low and one with it high. After the last bit it waits, drops the blank and restores the captured control value with the strobe bit set. After a final long wait it writes the low location bits, again with the strobe bit set, and pulses done. All waits are cycle counts given as parameters. The program word itself is computed elsewhere.

Top module: `serial_synth_loader`

## Requirements
- R1: While reset is held, ctrl_o is 0 and strobe_o, blank_o and done_o are low.
- R2: One cycle after a start is accepted, blank_o is high and ctrl_o is 0, and ctrl_i has been captured; the first strobe comes PRE_CYC + STB_CYC cycles after the accepting edge.
- R3: The first two strobed control values are 0x00 and then 0x01.
- R4: The frame that follows is sent in this order: the preamble bits 1, 0, 0, then the 5 location bits LSB first, then the 13 program bits LSB first; each frame bit appears on control bit 2.
- R5: Each frame bit is strobed twice: first with control bit 3 at 0, then with bit 3 at 1. Bit 0 stays 1 and every other bit stays 0 in these writes, giving 44 strobes per load.
- R6: strobe_o is high for single cycles only, ctrl_o is unchanged in the cycle before and during a strobe, and consecutive strobes are STB_CYC + 1 cycles apart.
- R7: blank_o falls POST_CYC + 1 cycles after the last strobe; in that same cycle ctrl_o becomes the captured value with bit 6 set.
- R8: FINAL_CYC cycles after blank_o falls, ctrl_o becomes location bits [3:0] with bit 6 set (bits 4, 5 and 7 zero), and done_o is high for exactly one cycle.
- R9: A start received while a load is in progress is ignored: the running load completes unchanged and no further load follows.
- R10: blank_o is high during every strobe and low while done_o is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a load; taken only when idle |
| word_i | input | 13 | Program word, captured at start |
| loc_i | input | 5 | Location address, captured at start |
| ctrl_i | input | 8 | Current control value, saved at start |
| ctrl_o | output | 8 | Control register drive value |
| strobe_o | output | 1 | One-cycle latch pulse for ctrl_o |
| blank_o | output | 1 | Display blank during the load |
| done_o | output | 1 | One-cycle pulse at the end of a load |

## Verification
A wrong step index or frame capture shows up at the port as a wrong strobed control value, at the first strobe after the fault and so within STB_CYC + 1 cycles. A stuck or miscounting wait timer moves the strobe times, the fall of blank or the done pulse by a whole number of cycles, and the bench checks these against cycle offsets taken from the accepting edge. A sequencer that wrongly re-accepts start during a load produces a second done pulse or extra strobes inside the observation window after done.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_WAIT,
    ST_STB,
    ST_TAIL,
    ST_SETTLE
  } slp_state_e;
endpackage

// File: rtl/slp_timer.sv
module slp_timer #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/slp_step_enc.sv
module slp_step_enc #(
  parameter int WORD_W   = 13,
  parameter int LOC_W    = 5,
  parameter int CTRL_W   = 8,
  parameter int DATA_BIT = 2,
  parameter int CLK_BIT  = 3,
  parameter int STEP_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [LOC_W-1:0]  loc_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [CTRL_W-1:0] ctrl_o
);
  localparam int BIT_W   = STEP_W - 1;
  localparam int FRAME_W = 3 + LOC_W + WORD_W;
  localparam int PAD_W   = 1 << BIT_W;

  logic [FRAME_W-1:0] frame_q;
  logic [PAD_W-1:0]   frame_pad;
  logic [STEP_W-1:0]  idx;

  // preamble sits in the low bits so it leaves first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    frame_q <= '0;
    else if (cap_i) frame_q <= {word_i, loc_i, 3'b001};
  end

  assign frame_pad = PAD_W'(frame_q);
  assign idx       = step_i - STEP_W'(2);

  always_comb begin
    ctrl_o = '0;
    if (step_i != '0) begin
      ctrl_o[0] = 1'b1;
      if (step_i >= STEP_W'(2)) begin
        ctrl_o[DATA_BIT] = frame_pad[idx[STEP_W-1:1]];
        ctrl_o[CLK_BIT]  = idx[0];
      end
    end
  end
endmodule

// File: rtl/serial_synth_loader.sv
module serial_synth_loader
  import slp_pkg::*;
#(
  parameter int WORD_W        = 13,
  parameter int LOC_W         = 5,
  parameter int CTRL_W        = 8,
  parameter int DATA_BIT      = 2,
  parameter int CLK_BIT       = 3,
  parameter int STB_BIT       = 6,
  parameter int RESTORE_LOC_W = 4,
  parameter int CNT_W         = 24,
  parameter int PRE_CYC       = 64,
  parameter int STB_CYC       = 4,
  parameter int POST_CYC      = 16,
  parameter int FINAL_CYC     = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [LOC_W-1:0]  loc_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              strobe_o,
  output logic              blank_o,
  output logic              done_o
);
  localparam int FRAME_W = 3 + LOC_W + WORD_W;
  localparam int N_STEP  = 2 + 2 * FRAME_W;
  localparam int BIT_W   = $clog2(FRAME_W + 1);
  localparam int STEP_W  = BIT_W + 1;

  slp_state_e        state_q;
  logic [STEP_W-1:0] step_q, step_sel;
  logic [CTRL_W-1:0] saved_q, ctrl_q, enc_val, stb_mask;
  logic [LOC_W-1:0]  loc_q;
  logic              strobe_q, blank_q, done_q;
  logic              tmr_load, tmr_zero, last_step, accept;
  logic [CNT_W-1:0]  tmr_val;

  assign accept    = (state_q == ST_IDLE) && start_i;
  assign last_step = (step_q == STEP_W'(N_STEP - 1));
  assign step_sel  = (state_q == ST_STB) ? step_q + 1'b1 : '0;
  assign stb_mask  = CTRL_W'(1) << STB_BIT;

  slp_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  slp_step_enc #(
    .WORD_W   (WORD_W),
    .LOC_W    (LOC_W),
    .CTRL_W   (CTRL_W),
    .DATA_BIT (DATA_BIT),
    .CLK_BIT  (CLK_BIT),
    .STEP_W   (STEP_W)
  ) i_enc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (accept),
    .word_i (word_i),
    .loc_i  (loc_i),
    .step_i (step_sel),
    .ctrl_o (enc_val)
  );

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE:   if (start_i)  begin tmr_load = 1'b1; tmr_val = CNT_W'(PRE_CYC - 1); end
      ST_PRE:    if (tmr_zero) begin tmr_load = 1'b1; tmr_val = CNT_W'(STB_CYC - 1); end
      ST_STB:    begin
        tmr_load = 1'b1;
        tmr_val  = last_step ? CNT_W'(POST_CYC - 1) : CNT_W'(STB_CYC - 1);
      end
      ST_TAIL:   if (tmr_zero) begin tmr_load = 1'b1; tmr_val = CNT_W'(FINAL_CYC - 1); end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      step_q   <= '0;
      saved_q  <= '0;
      loc_q    <= '0;
      ctrl_q   <= '0;
      strobe_q <= 1'b0;
      blank_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          done_q <= 1'b0;
          if (start_i) begin
            saved_q <= ctrl_i;
            loc_q   <= loc_i;
            ctrl_q  <= '0;
            blank_q <= 1'b1;
            state_q <= ST_PRE;
          end
        end
        ST_PRE: if (tmr_zero) begin
          step_q  <= '0;
          ctrl_q  <= enc_val;
          state_q <= ST_WAIT;
        end
        ST_WAIT: if (tmr_zero) begin
          strobe_q <= 1'b1;
          state_q  <= ST_STB;
        end
        ST_STB: begin
          strobe_q <= 1'b0;
          if (last_step) begin
            state_q <= ST_TAIL;
          end else begin
            step_q  <= step_q + 1'b1;
            ctrl_q  <= enc_val;
            state_q <= ST_WAIT;
          end
        end
        ST_TAIL: if (tmr_zero) begin
          blank_q <= 1'b0;
          ctrl_q  <= saved_q | stb_mask;
          state_q <= ST_SETTLE;
        end
        ST_SETTLE: if (tmr_zero) begin
          ctrl_q  <= CTRL_W'(loc_q[RESTORE_LOC_W-1:0]) | stb_mask;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ctrl_o   = ctrl_q;
  assign strobe_o = strobe_q;
  assign blank_o  = blank_q;
  assign done_o   = done_q;

  p_strobe_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);
  p_ctrl_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> $stable(ctrl_o));
  p_blank_at_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> blank_o);
  p_done_unblanked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !blank_o);
  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_busy_no_capture_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_o && start_i) |=> blank_o);
endmodule

// File: tb/test_serial_synth_loader.sv
module test_serial_synth_loader;
  localparam int PRE = 5, STB = 3, POST = 4, FIN = 6;
  localparam int NSTB = 44;
  localparam int K_FALL = PRE + STB + (NSTB - 1) * (STB + 1) + 1 + POST;
  localparam int K_DONE = K_FALL + FIN;
  // {word[12:0], loc[4:0], ctrl[7:0]}
  localparam logic [25:0] VECS [0:3] = '{
    {13'h0000, 5'h00, 8'hFF},
    {13'h1FFF, 5'h1F, 8'h00},
    {13'h0A53, 5'h16, 8'h3C},
    {13'h1234, 5'h09, 8'hC3}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [12:0] word = '0;
  logic [4:0]  loc = '0;
  logic [7:0]  ctrl_in = '0, ctrl;
  logic strobe, blank, done;

  int cyc = 0, t0 = 0, n_cmp = 0, n_bad = 0;
  int n_stb, n_done, k_fall, k_done;
  logic [7:0] stb_val [0:63];
  int stb_k [0:63];
  logic [7:0] ctrl_fall, ctrl_done;
  logic prev_blank = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  serial_synth_loader #(.PRE_CYC(PRE), .STB_CYC(STB), .POST_CYC(POST), .FINAL_CYC(FIN))
    i_serial_synth_loader (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .word_i(word), .loc_i(loc),
      .ctrl_i(ctrl_in), .ctrl_o(ctrl), .strobe_o(strobe), .blank_o(blank), .done_o(done));

  always @(negedge clk) begin
    if (strobe) begin
      if (n_stb < 64) begin stb_val[n_stb] = ctrl; stb_k[n_stb] = cyc - t0; end
      n_stb = n_stb + 1;
    end
    if (prev_blank && !blank) begin k_fall = cyc - t0; ctrl_fall = ctrl; end
    if (done) begin n_done = n_done + 1; k_done = cyc - t0; ctrl_done = ctrl; end
    prev_blank = blank;
  end

  always @(posedge clk) if (cyc > 100000) begin
    n_bad = n_bad + 1;
    $display("FAIL watchdog: run hung, act cyc=%0d exp <100000", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp = n_cmp + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_stb(input int i, input logic [12:0] w, input logic [4:0] l);
    logic b;
    int j;
    if (i == 0) return 8'h00;
    if (i == 1) return 8'h01;
    j = (i - 2) / 2;
    if (j == 0) b = 1'b1;
    else if (j < 3) b = 1'b0;
    else if (j < 8) b = l[j-3];
    else b = w[j-8];
    return 8'h01 | (8'(b) << 2) | (8'((i - 2) % 2) << 3);
  endfunction

  task automatic run(input logic [25:0] v, input bit inject);
    n_stb = 0; n_done = 0; k_fall = -1; k_done = -1;
    @(negedge clk);
    {word, loc, ctrl_in} = v;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t0 = cyc;
    ctrl_in = ~ctrl_in;
    chk(blank === 1'b1, "R2 blank after start", 32'(blank), 1);
    chk(ctrl === 8'h00, "R2 ctrl cleared", 32'(ctrl), 0);
    for (int k = 1; k < K_DONE + 12; k++) begin
      @(negedge clk);
      if (inject && k == 50) begin start = 1'b1; word = ~word; loc = ~loc; end
      if (inject && k == 51) start = 1'b0;
    end
    chk(n_stb == NSTB, "R6 strobe count", n_stb, NSTB);
    for (int i = 0; i < NSTB && i < n_stb; i++) begin
      chk(stb_val[i] === exp_stb(i, v[25:13], v[12:8]),
          i < 2 ? "R3 sync value" : (i % 2 == 0 ? "R4 data phase" : "R5 clock phase"),
          32'(stb_val[i]), 32'(exp_stb(i, v[25:13], v[12:8])));
      chk(stb_k[i] == PRE + STB + i * (STB + 1), "R6 strobe time", stb_k[i],
          PRE + STB + i * (STB + 1));
    end
    chk(k_fall == K_FALL, "R7 blank fall time", k_fall, K_FALL);
    chk(ctrl_fall === (v[7:0] | 8'h40), "R7 restore value", 32'(ctrl_fall), 32'(v[7:0] | 8'h40));
    chk(n_done == 1, inject ? "R9 single done" : "R8 single done", n_done, 1);
    chk(k_done == K_DONE, "R8 done time", k_done, K_DONE);
    chk(ctrl_done === ({4'h0, v[11:8]} | 8'h40), "R8 final value", 32'(ctrl_done),
        32'({4'h0, v[11:8]} | 8'h40));
    chk(blank === 1'b0 && ctrl === ({4'h0, v[11:8]} | 8'h40), "R9 idle after load",
        32'({blank, ctrl}), 32'({4'h0, v[11:8]} | 8'h40));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ctrl === 8'h00 && !strobe && !blank && !done, "R1 reset state",
        32'({ctrl, strobe, blank, done}), 0);
    rst_n = 1'b1;
    for (int n = 0; n < 4; n++) run(VECS[n], 1'b0);
    run(VECS[2], 1'b1);
    // reset in the middle of a load
    @(negedge clk);
    {word, loc, ctrl_in} = VECS[3];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(ctrl === 8'h00 && !strobe && !blank && !done, "R1 reset mid-load",
        32'({ctrl, strobe, blank, done}), 0);
    rst_n = 1'b1;
    run(VECS[1], 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule